// File: doc/BRIEF.md
# Perfect Destination Address Filter

This block decides, for each incoming Ethernet frame, whether the receive path keeps it. The decision is based on the six-byte destination address. The address arrives one byte per cycle, led by a start strobe that also carries the frame length. A table of sixteen exact-match addresses is compared against the address all at once. The result is then combined with the broadcast rule and four mode inputs: promiscuous, receive-all, pass-all-multicast and inverse filtering. Along with the accept decision, the block reports two flags for the receive status word. One says the frame passed only because filtering was off. The other says it passed as a multicast.

The table is replaced by a setup frame streamed in one byte per cycle. The frame is divided into twelve-byte slots, one per entry. A setup frame is taken only when its length is exactly sixteen slots. Any other length leaves the current table as it was. While a setup frame is streaming, decisions are held back. They are then taken against the newly loaded table.

Top module: `dst_addr_filter`

## Requirements
- R1: After reset the decision outputs are low and every table entry is the all-zero address, so a frame to 00:00:00:00:00:00 is accepted with both flags clear.
- R2: Address byte 0 comes with `addr_start` and `addr_valid`, and bytes 1 to 5 follow with `addr_valid`. The cycle after the sixth byte is sampled, `dec_valid` is high for exactly one cycle. Bytes beyond the sixth without a new start are ignored. A new start discards a partial address.
- R3: A setup frame replaces the whole table when its last byte (`setup_last`) arrives, but only if the frame is exactly 192 bytes. A setup frame of any other length leaves every entry unchanged.
- R4: Entry n is taken from setup bytes 12n+0, 12n+1, 12n+4, 12n+5, 12n+8 and 12n+9, in that order, as address bytes 0 to 5. All other setup bytes are ignored.
- R5: With no mode set, a non-broadcast frame is accepted exactly when its address equals some table entry. Both flags stay clear.
- R6: The all-ones address is accepted with both flags clear in every mode combination, including inverse filtering.
- R7: When `promisc_en` or `recv_all_en` is set, every non-broadcast frame is accepted with `dec_filt_fail` high and `dec_multicast` low.
- R8: When `all_mcast_en` is set and bit 0 of address byte 0 is 1, the frame is accepted with `dec_multicast` high. This rule ranks below R6 and R7.
- R9: When none of R6 to R8 applies, `inverse_en` inverts the table-match result of R5.
- R10: A frame whose `frame_len` is below 14 is rejected with both flags clear, ahead of every other rule.
- R11: From the first setup byte through the cycle of its last byte, no decision is issued. An address completed during that time is decided in the cycle after the load ends, against the table as it then stands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| setup_valid | input | 1 | Setup-frame byte present |
| setup_last | input | 1 | Marks the final byte of a setup frame |
| setup_byte | input | 8 | Setup-frame data byte |
| addr_start | input | 1 | First destination byte of a frame; samples `frame_len` |
| addr_valid | input | 1 | Destination byte present |
| addr_byte | input | 8 | Destination address byte, byte 0 first |
| frame_len | input | LEN_W | Frame length in bytes, valid with `addr_start` |
| promisc_en | input | 1 | Promiscuous mode |
| recv_all_en | input | 1 | Receive-all mode |
| all_mcast_en | input | 1 | Pass-all-multicast mode |
| inverse_en | input | 1 | Inverse filtering mode |
| dec_valid | output | 1 | One-cycle decision strobe |
| dec_accept | output | 1 | Frame accepted |
| dec_filt_fail | output | 1 | Accepted only because filtering was off |
| dec_multicast | output | 1 | Accepted as multicast |

## Verification
The table is loaded with sixteen distinct addresses. Half of them have the multicast bit set, and the non-address slot bytes carry filler. Every entry must then hit, and a single-bit change in each of its six bytes must miss, which separates a correct slot mapping from a shifted or partial one. A sweep over all sixteen mode combinations covers table hits, unicast and multicast misses and broadcast, each at frame lengths 13 and 14. This exposes any swap in the rule priority and any off-by-one in the short-frame limit. Truncated and overlong setup frames, a setup load overlapping an address, surplus address bytes and a restarted address cover the length check, the hold-off and the byte-count handling.

// File: rtl/dst_filt_pkg.sv
package dst_filt_pkg;
  localparam int ADDR_BYTES      = 6;
  localparam int SLOT_BYTES      = (ADDR_BYTES / 2) * 4;
  localparam int REL_W           = $clog2(SLOT_BYTES);
  localparam int BIDX_W          = $clog2(ADDR_BYTES);
  localparam int MIN_FRAME_BYTES = 14;

  typedef logic [ADDR_BYTES-1:0][7:0] mac_t;
  typedef logic [REL_W-1:0]           rel_t;
  typedef logic [BIDX_W-1:0]          bidx_t;

  typedef struct packed {
    logic accept;
    logic filt_fail;
    logic mcast;
  } verdict_t;

  // Address bytes sit in pairs at the start of each 4-byte group of a slot.
  function automatic logic rel_holds_addr(rel_t rel);
    int r;
    r = int'(rel);
    return ((r % 4) < 2) && ((r / 4) < (ADDR_BYTES / 2));
  endfunction

  function automatic bidx_t rel_to_bidx(rel_t rel);
    int r;
    r = int'(rel);
    return bidx_t'((r / 4) * 2 + (r % 4));
  endfunction

  // Fixed priority: length, broadcast, filtering off, multicast pass, table.
  function automatic verdict_t resolve(input logic short_frm, input logic bcast,
                                       input logic pass_all, input logic mc_en,
                                       input logic mc_bit, input logic inv,
                                       input logic hit);
    verdict_t v;
    v = '0;
    if (short_frm) begin
      v = '0;
    end else if (bcast) begin
      v.accept = 1'b1;
    end else if (pass_all) begin
      v.accept    = 1'b1;
      v.filt_fail = 1'b1;
    end else if (mc_en && mc_bit) begin
      v.accept = 1'b1;
      v.mcast  = 1'b1;
    end else begin
      v.accept = hit ^ inv;
    end
    return v;
  endfunction
endpackage

// File: rtl/dst_filt_loader.sv
module dst_filt_loader
  import dst_filt_pkg::*;
#(
  parameter int NUM_ENTRIES = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      setup_valid,
  input  logic                      setup_last,
  input  logic [7:0]                setup_byte,
  output mac_t [NUM_ENTRIES-1:0]    tab,
  output logic                      busy,
  output logic                      commit
);
  localparam int ENT_W = $clog2(NUM_ENTRIES);
  localparam logic [ENT_W-1:0] LAST_ENT = ENT_W'(NUM_ENTRIES - 1);
  localparam rel_t             LAST_REL = rel_t'(SLOT_BYTES - 1);

  logic [ENT_W-1:0]       ent_q;
  rel_t                   rel_q;
  logic                   over_q;
  logic                   loading_q;
  mac_t [NUM_ENTRIES-1:0] shadow_q;
  mac_t [NUM_ENTRIES-1:0] shadow_d;
  logic                   exact_len;

  assign exact_len = !over_q && (ent_q == LAST_ENT) && (rel_q == LAST_REL);
  assign commit    = setup_valid && setup_last && exact_len;
  assign busy      = loading_q || setup_valid;

  always_comb begin
    shadow_d = shadow_q;
    if (setup_valid && !over_q && rel_holds_addr(rel_q))
      shadow_d[ent_q][rel_to_bidx(rel_q)] = setup_byte;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_q     <= '0;
      rel_q     <= '0;
      over_q    <= 1'b0;
      loading_q <= 1'b0;
      shadow_q  <= '0;
      tab       <= '0;
    end else begin
      shadow_q <= shadow_d;
      if (commit)
        tab <= shadow_d;
      if (setup_valid) begin
        if (setup_last) begin
          ent_q     <= '0;
          rel_q     <= '0;
          over_q    <= 1'b0;
          loading_q <= 1'b0;
        end else begin
          loading_q <= 1'b1;
          if (rel_q == LAST_REL) begin
            rel_q <= '0;
            if (ent_q == LAST_ENT) over_q <= 1'b1;
            else                   ent_q  <= ent_q + 1'b1;
          end else begin
            rel_q <= rel_q + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/dst_filt_capture.sv
module dst_filt_capture
  import dst_filt_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             addr_start,
  input  logic             addr_valid,
  input  logic [7:0]       addr_byte,
  input  logic [LEN_W-1:0] frame_len,
  input  logic             blk,
  output mac_t             cand,
  output logic             short_frm,
  output logic             fire
);
  localparam int CNT_W = $clog2(ADDR_BYTES + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(ADDR_BYTES - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(ADDR_BYTES);
  localparam logic [LEN_W-1:0] MIN_LEN  = LEN_W'(MIN_FRAME_BYTES);

  mac_t             addr_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] idx;
  logic             short_q;
  logic             full_q;
  logic             take;
  logic             sixth_now;
  logic             start_now;

  assign start_now = addr_start && addr_valid;
  assign take      = addr_valid && (addr_start || (cnt_q != '0 && cnt_q != FULL_CNT));
  assign idx       = addr_start ? '0 : cnt_q;
  assign sixth_now = take && (idx == LAST_IDX);
  assign short_frm = start_now ? (frame_len < MIN_LEN) : short_q;
  assign fire      = (sixth_now || full_q) && !blk;

  always_comb begin
    cand = addr_q;
    if (take) cand[bidx_t'(idx)] = addr_byte;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      cnt_q   <= '0;
      short_q <= 1'b0;
      full_q  <= 1'b0;
    end else begin
      addr_q <= cand;
      if (take)      cnt_q   <= idx + 1'b1;
      if (start_now) short_q <= (frame_len < MIN_LEN);
      if (fire)           full_q <= 1'b0;
      else if (sixth_now) full_q <= 1'b1;
      else if (start_now) full_q <= 1'b0;
    end
  end
endmodule

// File: rtl/dst_filt_match.sv
module dst_filt_match
  import dst_filt_pkg::*;
#(
  parameter int NUM_ENTRIES = 16
) (
  input  mac_t [NUM_ENTRIES-1:0] tab,
  input  mac_t                   cand,
  output logic                   hit
);
  logic [NUM_ENTRIES-1:0] hit_vec;

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_ent
    assign hit_vec[i] = (tab[i] == cand);
  end

  assign hit = |hit_vec;
endmodule

// File: rtl/dst_addr_filter.sv
module dst_addr_filter
  import dst_filt_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int LEN_W       = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             setup_valid,
  input  logic             setup_last,
  input  logic [7:0]       setup_byte,
  input  logic             addr_start,
  input  logic             addr_valid,
  input  logic [7:0]       addr_byte,
  input  logic [LEN_W-1:0] frame_len,
  input  logic             promisc_en,
  input  logic             recv_all_en,
  input  logic             all_mcast_en,
  input  logic             inverse_en,
  output logic             dec_valid,
  output logic             dec_accept,
  output logic             dec_filt_fail,
  output logic             dec_multicast
);
  mac_t [NUM_ENTRIES-1:0] tab;
  mac_t                   cand;
  logic                   load_blk;
  logic                   tab_commit;
  logic                   short_frm;
  logic                   fire;
  logic                   hit;
  logic                   bcast;
  verdict_t               verdict;

  dst_filt_loader #(.NUM_ENTRIES(NUM_ENTRIES)) u_loader (
    .clk(clk), .rst_n(rst_n),
    .setup_valid(setup_valid), .setup_last(setup_last), .setup_byte(setup_byte),
    .tab(tab), .busy(load_blk), .commit(tab_commit)
  );

  dst_filt_capture #(.LEN_W(LEN_W)) u_capture (
    .clk(clk), .rst_n(rst_n),
    .addr_start(addr_start), .addr_valid(addr_valid), .addr_byte(addr_byte),
    .frame_len(frame_len), .blk(load_blk),
    .cand(cand), .short_frm(short_frm), .fire(fire)
  );

  dst_filt_match #(.NUM_ENTRIES(NUM_ENTRIES)) u_match (
    .tab(tab), .cand(cand), .hit(hit)
  );

  assign bcast   = (cand == '1);
  assign verdict = resolve(short_frm, bcast, promisc_en || recv_all_en,
                           all_mcast_en, cand[0][0], inverse_en, hit);

  always_ff @(posedge clk) begin
    if (!rst_n || !fire) begin
      dec_valid     <= 1'b0;
      dec_accept    <= 1'b0;
      dec_filt_fail <= 1'b0;
      dec_multicast <= 1'b0;
    end else begin
      dec_valid     <= 1'b1;
      dec_accept    <= verdict.accept;
      dec_filt_fail <= verdict.filt_fail;
      dec_multicast <= verdict.mcast;
    end
  end
endmodule

// File: rtl/dst_filt_chk.sv
module dst_filt_chk
  import dst_filt_pkg::*;
#(
  parameter int NUM_ENTRIES = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   dec_valid,
  input logic                   dec_accept,
  input logic                   dec_filt_fail,
  input logic                   dec_multicast,
  input logic                   load_blk,
  input logic                   tab_commit,
  input mac_t [NUM_ENTRIES-1:0] tab
);
  a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> !(dec_accept || dec_filt_fail || dec_multicast));

  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> !dec_valid);

  a_r3_table_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tab_commit |=> $stable(tab));

  a_r7_fail_flag_accepts: assert property (@(posedge clk) disable iff (!rst_n)
    dec_filt_fail |-> (dec_accept && !dec_multicast));

  a_r8_mcast_flag_accepts: assert property (@(posedge clk) disable iff (!rst_n)
    dec_multicast |-> dec_accept);

  a_r11_blocked_during_load: assert property (@(posedge clk) disable iff (!rst_n)
    load_blk |=> !dec_valid);
endmodule

bind dst_addr_filter dst_filt_chk #(.NUM_ENTRIES(NUM_ENTRIES)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .dec_valid(dec_valid), .dec_accept(dec_accept),
  .dec_filt_fail(dec_filt_fail), .dec_multicast(dec_multicast),
  .load_blk(load_blk), .tab_commit(tab_commit), .tab(tab)
);

// File: tb/dst_addr_filter_bench.sv
module dst_addr_filter_bench;
  localparam int N     = 16;
  localparam int LEN_W = 12;
  localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic setup_valid = 1'b0, setup_last = 1'b0;
  logic [7:0] setup_byte = '0;
  logic addr_start = 1'b0, addr_valid = 1'b0;
  logic [7:0] addr_byte = '0;
  logic [LEN_W-1:0] frame_len = '0;
  logic [3:0] mode_q = '0;  // {promisc, recv_all, all_mcast, inverse}
  logic dec_valid, dec_accept, dec_filt_fail, dec_multicast;

  int n_run = 0;
  int n_fail = 0;
  int cur_tab = 0;

  always #5 clk = ~clk;

  dst_addr_filter #(.NUM_ENTRIES(N), .LEN_W(LEN_W)) u_dst_addr_filter (
    .clk(clk), .rst_n(rst_n),
    .setup_valid(setup_valid), .setup_last(setup_last), .setup_byte(setup_byte),
    .addr_start(addr_start), .addr_valid(addr_valid), .addr_byte(addr_byte),
    .frame_len(frame_len),
    .promisc_en(mode_q[3]), .recv_all_en(mode_q[2]),
    .all_mcast_en(mode_q[1]), .inverse_en(mode_q[0]),
    .dec_valid(dec_valid), .dec_accept(dec_accept),
    .dec_filt_fail(dec_filt_fail), .dec_multicast(dec_multicast)
  );

  // Table contents: set 0 is the reset state, sets 1 and 2 are loaded.
  function automatic logic [7:0] gen_byte(int which, int n, int k);
    if (which == 0) return 8'h00;
    case (k)
      0: return 8'(n % 2);
      1: return (which == 1) ? 8'(8'hA0 + n) : 8'(8'hC0 + n);
      2: return 8'(n * 7);
      3: return 8'h3C;
      4: return ~8'(n);
      default: return 8'(n * 16 + 1);
    endcase
  endfunction

  function automatic logic [47:0] entry(int which, int n);
    logic [47:0] a;
    for (int k = 0; k < 6; k++) a[8*k +: 8] = gen_byte(which, n, k);
    return a;
  endfunction

  function automatic logic [7:0] setup_at(int which, int j);
    int n, r;
    n = j / 12;
    r = j % 12;
    if (j >= 192) return 8'hE7;
    case (r)
      0: return gen_byte(which, n, 0);
      1: return gen_byte(which, n, 1);
      4: return gen_byte(which, n, 2);
      5: return gen_byte(which, n, 3);
      8: return gen_byte(which, n, 4);
      9: return gen_byte(which, n, 5);
      default: return 8'(j) ^ 8'h5A;
    endcase
  endfunction

  function automatic logic exp_hit(logic [47:0] a);
    for (int n = 0; n < N; n++) if (entry(cur_tab, n) == a) return 1'b1;
    return 1'b0;
  endfunction

  // {accept, filt_fail, multicast}
  function automatic logic [2:0] exp_dec(logic [47:0] a, int len, logic [3:0] m);
    if (len < 14) return 3'b000;
    if (a == BCAST) return 3'b100;
    if (m[3] || m[2]) return 3'b110;
    if (m[1] && a[0]) return 3'b101;
    return {exp_hit(a) ^ m[0], 2'b00};
  endfunction

  function automatic string rule_of(logic [47:0] a, int len, logic [3:0] m);
    if (len < 14) return "R10";
    if (a == BCAST) return "R6";
    if (m[3] || m[2]) return "R7";
    if (m[1] && a[0]) return "R8";
    if (m[0]) return "R9";
    return "R5";
  endfunction

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_addr(input logic [47:0] a, input int len);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      addr_valid = 1'b1;
      addr_start = (k == 0);
      addr_byte  = a[8*k +: 8];
      frame_len  = LEN_W'(len);
    end
  endtask

  task automatic check_addr(input logic [47:0] a, input int len, input string req);
    logic [3:0] got, exp;
    send_addr(a, len);
    @(negedge clk);
    addr_valid = 1'b0;
    addr_start = 1'b0;
    got = {dec_valid, dec_accept, dec_filt_fail, dec_multicast};
    exp = {1'b1, exp_dec(a, len, mode_q)};
    chk(got == exp, req, 32'(got), 32'(exp));
  endtask

  task automatic send_setup(input int len, input int which);
    for (int j = 0; j < len; j++) begin
      @(negedge clk);
      setup_valid = 1'b1;
      setup_byte  = setup_at(which, j);
      setup_last  = (j == len - 1);
    end
    @(negedge clk);
    setup_valid = 1'b0;
    setup_last  = 1'b0;
    if (len == N * 12) cur_tab = which;
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  initial begin
    logic [3:0] got;
    int stray;
    logic [47:0] miss_list [4];

    // R1: outputs quiet in reset, zero table afterwards
    repeat (3) @(negedge clk);
    got = {dec_valid, dec_accept, dec_filt_fail, dec_multicast};
    chk(got == 4'b0000, "R1 reset outputs", 32'(got), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check_addr(48'h0, 60, "R1 zero table hit");
    check_addr(entry(1, 2), 60, "R1 non-zero misses");
    check_addr(BCAST, 13, "R10 short broadcast");

    // R4/R5: load set 1, every entry hits, single-bit changes miss
    send_setup(192, 1);
    for (int n = 0; n < N; n++) begin
      check_addr(entry(1, n), 64, "R4 R5 entry hit");
      for (int k = 0; k < 6; k++)
        check_addr(entry(1, n) ^ (48'h2 << (8 * k)), 64, "R4 R5 near miss");
    end

    // R6-R10: every mode combination against each address class
    miss_list[0] = entry(1, 3);
    miss_list[1] = entry(1, 6);
    miss_list[2] = 48'h1122_3344_5502;
    miss_list[3] = 48'h1122_3344_5503;
    for (int m = 0; m < 16; m++) begin
      @(negedge clk);
      mode_q = 4'(m);
      for (int c = 0; c < 5; c++) begin
        for (int l = 13; l <= 14; l++) begin
          logic [47:0] a;
          a = (c == 4) ? BCAST : miss_list[c];
          check_addr(a, l, rule_of(a, l, mode_q));
        end
      end
    end
    @(negedge clk);
    mode_q = '0;

    // R2: bytes past the sixth are ignored
    check_addr(entry(1, 5), 60, "R2 decision");
    stray = 0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      if (dec_valid) stray++;
      addr_valid = 1'b1;
      addr_byte  = 8'h77;
    end
    @(negedge clk);
    addr_valid = 1'b0;
    if (dec_valid) stray++;
    @(negedge clk);
    if (dec_valid) stray++;
    chk(stray == 0, "R2 surplus bytes ignored", 32'(stray), 32'h0);

    // R2: restart discards a partial address
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      addr_valid = 1'b1;
      addr_start = (k == 0);
      addr_byte  = 8'h99;
      frame_len  = LEN_W'(60);
    end
    check_addr(entry(1, 2), 60, "R2 restart");

    // R3: wrong lengths keep set 1
    send_setup(191, 2);
    check_addr(entry(1, 4), 60, "R3 short setup keeps old");
    check_addr(entry(2, 4), 60, "R3 short setup not loaded");
    send_setup(193, 2);
    check_addr(entry(1, 4), 60, "R3 long setup keeps old");
    check_addr(entry(2, 4), 60, "R3 long setup not loaded");

    // R11: address completes while set 2 is loading
    stray = 0;
    for (int j = 0; j < 192; j++) begin
      @(negedge clk);
      if (dec_valid) stray++;
      setup_valid = 1'b1;
      setup_byte  = setup_at(2, j);
      setup_last  = (j == 191);
      if (j >= 20 && j < 26) begin
        addr_valid = 1'b1;
        addr_start = (j == 20);
        addr_byte  = entry(2, 9)[8*(j-20) +: 8];
        frame_len  = LEN_W'(60);
      end else begin
        addr_valid = 1'b0;
        addr_start = 1'b0;
      end
    end
    @(negedge clk);
    setup_valid = 1'b0;
    setup_last  = 1'b0;
    if (dec_valid) stray++;
    chk(stray == 0, "R11 no decision during load", 32'(stray), 32'h0);
    cur_tab = 2;
    @(negedge clk);
    got = {dec_valid, dec_accept, dec_filt_fail, dec_multicast};
    chk(got == 4'b1100, "R11 held decision on new table", 32'(got), 32'hC);
    check_addr(entry(1, 4), 60, "R3 exact setup replaces table");
    check_addr(entry(2, 0), 60, "R3 exact setup new entry");

    summary();
    $finish;
  end
endmodule